// File: doc/BRIEF.md
# Coprocessor Host Control Register Block

This block sits between a host processor and a coprocessor board. It holds two host-writable registers, a control word and a window word, and offers one status byte for reading. The control word swaps two communication RAMs between the host and the coprocessor. It also selects a display buffer, and on rising bits it launches the math coprocessor, launches the vector generator, or clears the polygon buffer.

The window word tells an external address decoder which source backs the host's shared window. The sources are a ROM page, an upper ROM page, the communication RAM or the coprocessor RAM. The same word picks a RAM bank and an alpha-map select. Host writes through the window are passed on only when the window points at a RAM.

Busy flags follow the two engines from their start to their done pulse. A math-engine completion raises a fast interrupt toward the host, and the interrupt holds until it is acknowledged.

Top module: `hc_host_regs`

## Requirements
- R1: Control bit 7 selects the communication RAM for the host (`host_ram_sel`). The coprocessor gets the other RAM (`cop_ram_sel` is always its inverse). After reset the host has RAM 0.
- R2: A control write whose bit 4 is 1 while the stored bit 4 was 0 makes `mb_start` high for exactly one cycle, in the cycle after the write. Writing bit 4 as 1 again while it is already 1 gives no pulse.
- R3: Control bit 2 drives `vg_start` under the same rising rule and timing as R2.
- R4: A control write with bit 0 = 1 while the stored bit 0 was 0 gives a one-cycle `poly_clear` in the next cycle. Control bit 1 is held on `disp_buf_sel`.
- R5: The status byte has these bits:
  - bit 5 = 1 when the math engine is idle;
  - bit 6 = 1 while the vector generator is busy;
  - bit 7 = the `vblank` input;
  - bits 4:0 always 0.
- R6: Each busy flag sets on its start, in the same cycle the start pulse appears. It clears in the cycle after a one-cycle done pulse. A start and a done in the same cycle leave the flag set.
- R7: `mb_done` raises `firq` in the next cycle. `firq` stays high until a `firq_ack` pulse, and a done in the same cycle as an ack wins.
- R8: In the window word, bits 4:3 give `win_src`:
  - 0 = low ROM page;
  - 1 = upper ROM page;
  - 2 = communication RAM;
  - 3 = coprocessor RAM.
  Bits 6:5 give `ram_bank` and bit 7 gives `alpha_sel`.
- R9: `rom_page` is {0, bit 1} for source 0, bits 2:1 for source 1, and 0 for the RAM sources.
- R10: `win_wr_out` follows `win_wr_en` only when `win_src` is 2 or 3. For the ROM sources the write is dropped.
- R11: Reset clears both registers and all flags, so the outputs are `status` = 0x20, `firq` = 0 and `win_src` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = window word |
| wr_data | input | 8 | Host write data |
| vblank | input | 1 | Vertical blank level |
| mb_done | input | 1 | One-cycle math engine done pulse |
| vg_done | input | 1 | One-cycle vector generator done pulse |
| firq_ack | input | 1 | Fast interrupt acknowledge pulse |
| win_wr_en | input | 1 | Host write strobe through the shared window |
| status | output | 8 | Status byte |
| mb_start | output | 1 | Math engine start pulse |
| vg_start | output | 1 | Vector generator start pulse |
| poly_clear | output | 1 | Polygon buffer clear pulse |
| disp_buf_sel | output | 1 | Display buffer select |
| host_ram_sel | output | 1 | Communication RAM seen by the host |
| cop_ram_sel | output | 1 | Communication RAM seen by the coprocessor |
| win_src | output | 2 | Shared window source code |
| rom_page | output | 2 | ROM page within the window |
| ram_bank | output | 2 | RAM bank select |
| alpha_sel | output | 1 | Alpha-map select |
| firq | output | 1 | Fast interrupt request to the host |
| win_wr_out | output | 1 | Gated window write strobe |

## Verification
The bench writes a start bit twice. A design that compared against the write data instead of the stored word would fire a second start. The bench drives a start together with a done, and a done together with an acknowledge. A wrong priority would show an idle engine or drop an interrupt. It checks the mixed status polarity: an inverted idle bit would read 0x00 after reset rather than 0x20. It also checks the ROM page for both ROM sources and window writes under every source. A missing gate would pass writes into ROM.

// File: rtl/hc_pkg.sv
package hc_pkg;
    localparam int DW        = 8;
    localparam int B_CLR     = 0;
    localparam int B_DBUF    = 1;
    localparam int B_VG      = 2;
    localparam int B_MB      = 4;
    localparam int B_RAMSW   = 7;
    localparam int S_MBIDLE  = 5;
    localparam int S_VGBUSY  = 6;
    localparam int S_VBLANK  = 7;
    localparam int NFLAG     = 3;
    localparam int F_MB      = 0;
    localparam int F_VG      = 1;
    localparam int F_IRQ     = 2;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic          mb_go;
        logic          vg_go;
        logic          clr;
    } ctrl_st_t;

    typedef struct packed {
        logic [DW-1:0] win;
    } win_st_t;
endpackage

// File: rtl/hc_ctrl_decode.sv
module hc_ctrl_decode
    import hc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wd,
    output logic          mb_rise,
    output logic          vg_rise,
    output logic          mb_go,
    output logic          vg_go,
    output logic          clr,
    output logic [DW-1:0] ctrl
);
    ctrl_st_t st_d, st_q;

    always_comb begin
        mb_rise = we && wd[B_MB] && !st_q.ctrl[B_MB];
        vg_rise = we && wd[B_VG] && !st_q.ctrl[B_VG];
        st_d       = st_q;
        st_d.mb_go = mb_rise;
        st_d.vg_go = vg_rise;
        st_d.clr   = we && wd[B_CLR] && !st_q.ctrl[B_CLR];
        if (we) st_d.ctrl = wd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mb_go = st_q.mb_go;
    assign vg_go = st_q.vg_go;
    assign clr   = st_q.clr;
    assign ctrl  = st_q.ctrl;
endmodule

// File: rtl/hc_flag.sv
module hc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    logic q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (clr) q_d = 1'b0;
        if (set) q_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/hc_window.sv
module hc_window
    import hc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [DW-1:0] wd,
    input  logic       win_wr_en,
    output logic [1:0] win_src,
    output logic [1:0] rom_page,
    output logic [1:0] ram_bank,
    output logic       alpha_sel,
    output logic       win_wr_out
);
    win_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.win = wd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        win_src   = st_q.win[4:3];
        ram_bank  = st_q.win[6:5];
        alpha_sel = st_q.win[7];
        unique case (win_src)
            2'd0:    rom_page = {1'b0, st_q.win[1]};
            2'd1:    rom_page = st_q.win[2:1];
            default: rom_page = 2'd0;
        endcase
        win_wr_out = win_wr_en && win_src[1];
    end
endmodule

// File: rtl/hc_host_regs.sv
module hc_host_regs
    import hc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       vblank,
    input  logic       mb_done,
    input  logic       vg_done,
    input  logic       firq_ack,
    input  logic       win_wr_en,
    output logic [7:0] status,
    output logic       mb_start,
    output logic       vg_start,
    output logic       poly_clear,
    output logic       disp_buf_sel,
    output logic       host_ram_sel,
    output logic       cop_ram_sel,
    output logic [1:0] win_src,
    output logic [1:0] rom_page,
    output logic [1:0] ram_bank,
    output logic       alpha_sel,
    output logic       firq,
    output logic       win_wr_out
);
    logic          mb_rise, vg_rise;
    logic [DW-1:0] ctrl;
    logic [NFLAG-1:0] f_set, f_clr, f_q;

    hc_ctrl_decode u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && !wr_sel), .wd(wr_data),
        .mb_rise(mb_rise), .vg_rise(vg_rise),
        .mb_go(mb_start), .vg_go(vg_start), .clr(poly_clear),
        .ctrl(ctrl)
    );

    hc_window u_win (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && wr_sel), .wd(wr_data),
        .win_wr_en(win_wr_en),
        .win_src(win_src), .rom_page(rom_page), .ram_bank(ram_bank),
        .alpha_sel(alpha_sel), .win_wr_out(win_wr_out)
    );

    always_comb begin
        f_set        = '0;
        f_clr        = '0;
        f_set[F_MB]  = mb_rise;
        f_clr[F_MB]  = mb_done;
        f_set[F_VG]  = vg_rise;
        f_clr[F_VG]  = vg_done;
        f_set[F_IRQ] = mb_done;
        f_clr[F_IRQ] = firq_ack;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        hc_flag u_flag (
            .clk(clk), .rst_n(rst_n),
            .set(f_set[i]), .clr(f_clr[i]), .q(f_q[i])
        );
    end

    always_comb begin
        status           = '0;
        status[S_MBIDLE] = !f_q[F_MB];
        status[S_VGBUSY] = f_q[F_VG];
        status[S_VBLANK] = vblank;
    end

    assign firq         = f_q[F_IRQ];
    assign disp_buf_sel = ctrl[B_DBUF];
    assign host_ram_sel = ctrl[B_RAMSW];
    assign cop_ram_sel  = !ctrl[B_RAMSW];
endmodule

// File: rtl/hc_host_regs_chk.sv
module hc_host_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] wr_data,
    input logic       mb_done,
    input logic       firq_ack,
    input logic [7:0] status,
    input logic       mb_start,
    input logic       host_ram_sel,
    input logic       cop_ram_sel,
    input logic [1:0] win_src,
    input logic       win_wr_out,
    input logic       firq
);
    p_ram_swap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_ram_sel != cop_ram_sel);
    p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mb_start) |-> $past(wr_en && !wr_sel && wr_data[4]));
    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mb_start |=> !mb_start);
    p_status_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status[4:0] == 5'd0);
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_done && !(wr_en && !wr_sel && wr_data[4])) |=> status[5]);
    p_firq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (firq && !firq_ack) |=> firq);
    p_firq_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mb_done |=> firq);
    p_win_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        win_wr_out |-> win_src[1]);
endmodule

bind hc_host_regs hc_host_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .mb_done(mb_done), .firq_ack(firq_ack),
    .status(status), .mb_start(mb_start), .host_ram_sel(host_ram_sel),
    .cop_ram_sel(cop_ram_sel), .win_src(win_src), .win_wr_out(win_wr_out),
    .firq(firq)
);

// File: tb/tb_hc_host_regs.sv
module tb_hc_host_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, wr_sel = 0, vblank = 0, mb_done = 0, vg_done = 0;
    logic firq_ack = 0, win_wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] status;
    logic mb_start, vg_start, poly_clear, disp_buf_sel, host_ram_sel, cop_ram_sel;
    logic [1:0] win_src, rom_page, ram_bank;
    logic alpha_sel, firq, win_wr_out;
    int errors = 0, checks = 0;

    always #4 clk = ~clk;

    hc_host_regs dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic t_reset;
        chk("R11 status", status, 8'h20);
        chk("R11 firq", firq, 0);
        chk("R11 win_src", win_src, 0);
        chk("R1 host ram reset", host_ram_sel, 0);
        chk("R1 cop ram reset", cop_ram_sel, 1);
    endtask

    task automatic t_swap;
        wr(0, 8'h80);
        chk("R1 host ram", host_ram_sel, 1);
        chk("R1 cop ram", cop_ram_sel, 0);
        wr(0, 8'h02);
        chk("R1 back", host_ram_sel, 0);
        chk("R4 disp buf", disp_buf_sel, 1);
        wr(0, 8'h00);
    endtask

    task automatic t_mb_start;
        wr(0, 8'h10);
        chk("R2 pulse", mb_start, 1);
        chk("R6 busy at start", status[5], 0);
        @(negedge clk);
        chk("R2 one cycle", mb_start, 0);
        wr(0, 8'h10);
        chk("R2 no repeat", mb_start, 0);
        mb_done = 1; @(negedge clk); mb_done = 0;
        chk("R6 idle after done", status[5], 1);
        chk("R7 firq raised", firq, 1);
        @(negedge clk);
        chk("R7 firq held", firq, 1);
        firq_ack = 1; mb_done = 1; @(negedge clk); firq_ack = 0; mb_done = 0;
        chk("R7 done beats ack", firq, 1);
        firq_ack = 1; @(negedge clk); firq_ack = 0;
        chk("R7 ack clears", firq, 0);
        wr(0, 8'h00);
        @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 8'h10; mb_done = 1;
        @(negedge clk); wr_en = 0; mb_done = 0;
        chk("R6 start beats done", status[5], 0);
        mb_done = 1; @(negedge clk); mb_done = 0;
        firq_ack = 1; @(negedge clk); firq_ack = 0;
        wr(0, 8'h00);
    endtask

    task automatic t_vg_clr;
        wr(0, 8'h05);
        chk("R3 vg pulse", vg_start, 1);
        chk("R4 clear pulse", poly_clear, 1);
        chk("R5 vg busy bit", status, 8'h60);
        @(negedge clk);
        chk("R3 vg one cycle", vg_start, 0);
        wr(0, 8'h05);
        chk("R3 no repeat", vg_start, 0);
        chk("R4 no repeat", poly_clear, 0);
        vg_done = 1; @(negedge clk); vg_done = 0;
        chk("R6 vg cleared", status[6], 0);
        vblank = 1; @(negedge clk);
        chk("R5 vblank", status, 8'ha0);
        vblank = 0;
        wr(0, 8'h00);
    endtask

    task automatic t_window;
        wr(1, 8'hC2);
        chk("R8 src0", win_src, 0);
        chk("R8 bank", ram_bank, 2);
        chk("R8 alpha", alpha_sel, 1);
        chk("R9 page src0", rom_page, 1);
        win_wr_en = 1; #1;
        chk("R10 rom0 write dropped", win_wr_out, 0);
        win_wr_en = 0;
        wr(1, 8'h0C);
        chk("R9 page src1", rom_page, 2);
        win_wr_en = 1; #1;
        chk("R10 rom1 write dropped", win_wr_out, 0);
        win_wr_en = 0;
        wr(1, 8'h16);
        chk("R8 src2", win_src, 2);
        chk("R9 page ram", rom_page, 0);
        win_wr_en = 1; #1;
        chk("R10 comm ram write", win_wr_out, 1);
        win_wr_en = 0;
        wr(1, 8'h18);
        win_wr_en = 1; #1;
        chk("R10 cop ram write", win_wr_out, 1);
        win_wr_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_swap();
        t_mb_start();
        t_vg_clr();
        t_window();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule